// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block takes interrupt events raised by devices on a shared expansion bus and folds them onto a bank of internal interrupt lines. Each event carries the slot number of the device and the interrupt pin that changed, numbered 0 to 3 for the first to the fourth pin. A fixed routing table turns the pair into an internal line index. Lines are numbered from a global base of 32, so internal line k is global interrupt 32 + k.

The routing table has four cases. The integrated peripheral slot (5) keeps its four pins apart. The graphics slot (6) and the network slot (7) each own one line. The expansion slots (8 to 12) rotate their pin numbers by slot position, so that pin A of neighbouring cards lands on different lines. Any other slot is not translated: its pin number comes out unchanged as the interrupt number, and the CPU request is not affected.

For a routed event, two configuration words decide how the single CPU interrupt request moves. The first holds one edge-mode bit per line and the second one polarity bit per line. In edge mode the request gives a one-cycle pulse. In level mode the request takes the value of the line's polarity bit and holds it. Each event produces a registered interrupt number, a flag that tells whether it was translated, and a one-cycle valid strobe.

Top module: `irq_slot_router`

## Requirements
- R1: While and after reset, `num_vld_o`, `num_routed_o`, `cpu_irq_o` and `irq_num_o` are all 0.
- R2: An event from slot 5 with pin p gives `irq_num_o` = 32 + p and `num_routed_o` = 1, one cycle after the event.
- R3: An event from slot 6 gives interrupt number 36 (line 4) and an event from slot 7 gives 37 (line 5), whatever the pin.
- R4: An event from slot s in the range 8 to 12 with pin p gives interrupt number 32 + (s − 8 + p) + 6. Slot 8 pin 0 gives 38 and slot 12 pin 3 gives 45.
- R5: An event from any other slot (for example 3 or 13) gives `irq_num_o` = p and `num_routed_o` = 0, and leaves a held level on `cpu_irq_o` unchanged.
- R6: `num_vld_o` is high for exactly the one cycle after each event cycle and low otherwise. `irq_num_o` holds its value between events.
- R7: A routed event whose line has its bit set in `edge_cfg_i` (bit k for line k) drives `cpu_irq_o` high for exactly one cycle, the cycle after the event, and then low.
- R8: A routed event whose line has its edge bit clear sets `cpu_irq_o` to that line's bit of `pol_cfg_i` (bit k for line k) one cycle later and holds it until the next routed event.
- R9: When a line has both its edge bit and its polarity bit set, edge mode wins: the request pulses for one cycle and does not stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle strobe: a device interrupt pin changed |
| evt_slot_i | input | 5 | Slot number of the signalling device |
| evt_pin_i | input | 2 | Interrupt pin, 0 to 3 |
| edge_cfg_i | input | 32 | Per-line edge-mode bits |
| pol_cfg_i | input | 32 | Per-line level polarity bits |
| irq_num_o | output | 6 | Registered global interrupt number of the last event |
| num_routed_o | output | 1 | The last event was translated to an internal line |
| num_vld_o | output | 1 | One-cycle strobe for a new interrupt number |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A wrong routing-table entry shows up at `irq_num_o` in the first cycle after the event for the faulty slot and pin. For this reason the bench covers each slot class and both ends of the expansion range. A pulse state that is wrong or stuck shows as a request that stays high one cycle too long. A wrong trigger-mode choice shows as a level that is held when a pulse was due, or the reverse. Both appear within two cycles of the event. A passthrough event that disturbs the request shows up at once as a dropped level.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned SLOT_PERIPH   = 5;
    localparam int unsigned SLOT_GFX      = 6;
    localparam int unsigned SLOT_NET      = 7;
    localparam int unsigned SLOT_EXP_LO   = 8;
    localparam int unsigned SLOT_EXP_HI   = 12;
    localparam int unsigned LINE_GFX      = 4;
    localparam int unsigned LINE_NET      = 5;
    localparam int unsigned LINE_EXP_BASE = 6;

    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2
    } trig_kind_e;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
    import irq_route_pkg::*;
#(
    parameter int unsigned SLOT_W   = 5,
    parameter int unsigned PIN_W    = 2,
    parameter int unsigned LINE_W   = 5,
    parameter int unsigned GNUM_W   = 6,
    parameter int unsigned IRQ_BASE = 32
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [PIN_W-1:0]  pin_i,
    output logic              routed_o,
    output logic [LINE_W-1:0] line_o,
    output logic [GNUM_W-1:0] gnum_o
);
    always_comb begin
        routed_o = 1'b1;
        line_o   = '0;
        if (32'(slot_i) == SLOT_PERIPH) begin
            line_o = LINE_W'(pin_i);
        end else if (32'(slot_i) == SLOT_GFX) begin
            line_o = LINE_W'(LINE_GFX);
        end else if (32'(slot_i) == SLOT_NET) begin
            line_o = LINE_W'(LINE_NET);
        end else if (32'(slot_i) >= SLOT_EXP_LO && 32'(slot_i) <= SLOT_EXP_HI) begin
            line_o = LINE_W'(32'(slot_i) - SLOT_EXP_LO + 32'(pin_i) + LINE_EXP_BASE);
        end else begin
            routed_o = 1'b0;
        end
        gnum_o = routed_o ? GNUM_W'(32'(line_o) + IRQ_BASE) : GNUM_W'(pin_i);
    end
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned LINE_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_i,
    input  logic                 routed_i,
    input  logic [LINE_W-1:0]    line_i,
    input  logic [NUM_LINES-1:0] edge_cfg_i,
    input  logic [NUM_LINES-1:0] pol_cfg_i,
    output logic                 irq_o
);
    typedef struct packed {
        logic irq;
        logic pulse;
    } trig_state_t;

    trig_state_t st_d, st_q;
    trig_kind_e  kind;

    always_comb begin
        kind = TRIG_NONE;
        if (evt_i && routed_i) begin
            kind = edge_cfg_i[line_i] ? TRIG_EDGE : TRIG_LEVEL;
        end
        st_d = st_q;
        if (st_q.pulse) begin
            st_d.irq   = 1'b0;
            st_d.pulse = 1'b0;
        end
        case (kind)
            TRIG_EDGE: begin
                st_d.irq   = 1'b1;
                st_d.pulse = 1'b1;
            end
            TRIG_LEVEL: begin
                st_d.irq   = pol_cfg_i[line_i];
                st_d.pulse = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_edge_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && routed_i && edge_cfg_i[line_i]) |=> irq_o);
    p_pulse_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && !(evt_i && routed_i && edge_cfg_i[line_i])) |=> !irq_o);
    p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && routed_i && !edge_cfg_i[line_i]) |=> (irq_o == $past(pol_cfg_i[line_i])));
    p_unrouted_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pulse && !(evt_i && routed_i)) |=> $stable(irq_o));
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned IRQ_BASE  = 32,
    parameter int unsigned SLOT_W    = 5,
    parameter int unsigned PIN_W     = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        evt_i,
    input  logic [SLOT_W-1:0]                           evt_slot_i,
    input  logic [PIN_W-1:0]                            evt_pin_i,
    input  logic [NUM_LINES-1:0]                        edge_cfg_i,
    input  logic [NUM_LINES-1:0]                        pol_cfg_i,
    output logic [$clog2(IRQ_BASE+NUM_LINES)-1:0]       irq_num_o,
    output logic                                        num_routed_o,
    output logic                                        num_vld_o,
    output logic                                        cpu_irq_o
);
    localparam int unsigned LINE_W = $clog2(NUM_LINES);
    localparam int unsigned GNUM_W = $clog2(IRQ_BASE + NUM_LINES);

    typedef struct packed {
        logic              vld;
        logic              routed;
        logic [GNUM_W-1:0] gnum;
    } num_state_t;

    logic              map_routed;
    logic [LINE_W-1:0] map_line;
    logic [GNUM_W-1:0] map_gnum;
    num_state_t        ns_d, ns_q;

    irq_slot_map #(
        .SLOT_W  (SLOT_W),
        .PIN_W   (PIN_W),
        .LINE_W  (LINE_W),
        .GNUM_W  (GNUM_W),
        .IRQ_BASE(IRQ_BASE)
    ) u_map (
        .slot_i  (evt_slot_i),
        .pin_i   (evt_pin_i),
        .routed_o(map_routed),
        .line_o  (map_line),
        .gnum_o  (map_gnum)
    );

    irq_trigger #(
        .NUM_LINES(NUM_LINES),
        .LINE_W   (LINE_W)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .routed_i  (map_routed),
        .line_i    (map_line),
        .edge_cfg_i(edge_cfg_i),
        .pol_cfg_i (pol_cfg_i),
        .irq_o     (cpu_irq_o)
    );

    always_comb begin
        ns_d     = ns_q;
        ns_d.vld = evt_i;
        if (evt_i) begin
            ns_d.routed = map_routed;
            ns_d.gnum   = map_gnum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ns_q <= '0;
        else        ns_q <= ns_d;
    end

    assign irq_num_o    = ns_q.gnum;
    assign num_routed_o = ns_q.routed;
    assign num_vld_o    = ns_q.vld;

    p_vld_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> num_vld_o);
    p_hold_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> (!num_vld_o && $stable(irq_num_o)));
    p_periph_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && 32'(evt_slot_i) == SLOT_PERIPH) |=>
        (32'(irq_num_o) == IRQ_BASE + 32'($past(evt_pin_i))));
    p_routed_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (num_vld_o && num_routed_o) |-> (32'(irq_num_o) >= IRQ_BASE));
endmodule

// File: tb/irq_slot_router_bench.sv
module irq_slot_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic [4:0]  evt_slot_i = '0;
    logic [1:0]  evt_pin_i = '0;
    logic [31:0] edge_cfg_i = '0;
    logic [31:0] pol_cfg_i = '0;
    logic [5:0]  irq_num_o;
    logic        num_routed_o, num_vld_o, cpu_irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    irq_slot_router u_irq_slot_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .evt_slot_i  (evt_slot_i),
        .evt_pin_i   (evt_pin_i),
        .edge_cfg_i  (edge_cfg_i),
        .pol_cfg_i   (pol_cfg_i),
        .irq_num_o   (irq_num_o),
        .num_routed_o(num_routed_o),
        .num_vld_o   (num_vld_o),
        .cpu_irq_o   (cpu_irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one event at a falling edge; return at the next falling edge,
    // after the registering rising edge.
    task automatic send(input int slot, input int pin);
        @(negedge clk);
        evt_slot_i = 5'(slot);
        evt_pin_i  = 2'(pin);
        evt_i      = 1'b1;
        @(negedge clk);
        evt_i      = 1'b0;
    endtask

    task automatic route_check(input int slot, input int pin, input int exp_num,
                               input bit exp_routed, input string req);
        send(slot, pin);
        chk(32'(irq_num_o) == exp_num, req, int'(irq_num_o), exp_num);
        chk(num_routed_o == exp_routed, req, int'(num_routed_o), int'(exp_routed));
        chk(num_vld_o == 1'b1, "R6 valid", int'(num_vld_o), 1);
    endtask

    task automatic t_reset;
        chk(num_vld_o == 0 && cpu_irq_o == 0, "R1 strobe/irq", int'({num_vld_o, cpu_irq_o}), 0);
        chk(irq_num_o == 0 && num_routed_o == 0, "R1 number", int'(irq_num_o), 0);
    endtask

    task automatic t_periph;
        for (int p = 0; p < 4; p++) route_check(5, p, 32 + p, 1'b1, "R2 slot5");
    endtask

    task automatic t_fixed;
        route_check(6, 3, 36, 1'b1, "R3 slot6");
        route_check(7, 1, 37, 1'b1, "R3 slot7");
    endtask

    task automatic t_expansion;
        route_check(8, 0, 38, 1'b1, "R4 slot8");
        route_check(10, 1, 41, 1'b1, "R4 slot10");
        route_check(12, 3, 45, 1'b1, "R4 slot12");
    endtask

    task automatic t_hold;
        @(negedge clk);
        chk(num_vld_o == 0, "R6 strobe low", int'(num_vld_o), 0);
        chk(irq_num_o == 45, "R6 number held", int'(irq_num_o), 45);
    endtask

    task automatic t_level;
        edge_cfg_i = '0;
        pol_cfg_i  = 32'h0000_0004;
        send(5, 2);
        chk(cpu_irq_o == 1, "R8 level high", int'(cpu_irq_o), 1);
        repeat (3) @(negedge clk);
        chk(cpu_irq_o == 1, "R8 level held", int'(cpu_irq_o), 1);
        send(5, 0);
        chk(cpu_irq_o == 0, "R8 level low", int'(cpu_irq_o), 0);
    endtask

    task automatic t_passthrough;
        pol_cfg_i = 32'h0000_0004;
        send(5, 2);
        route_check(3, 2, 2, 1'b0, "R5 slot3");
        chk(cpu_irq_o == 1, "R5 irq kept", int'(cpu_irq_o), 1);
        route_check(13, 1, 1, 1'b0, "R5 slot13");
        chk(cpu_irq_o == 1, "R5 irq kept", int'(cpu_irq_o), 1);
    endtask

    task automatic t_edge;
        edge_cfg_i = 32'h0000_0010;
        pol_cfg_i  = '0;
        send(5, 0);
        chk(cpu_irq_o == 0, "R7 pre", int'(cpu_irq_o), 0);
        send(6, 0);
        chk(cpu_irq_o == 1, "R7 pulse", int'(cpu_irq_o), 1);
        @(negedge clk);
        chk(cpu_irq_o == 0, "R7 pulse ends", int'(cpu_irq_o), 0);
    endtask

    task automatic t_edge_wins;
        edge_cfg_i = 32'h0000_0020;
        pol_cfg_i  = 32'h0000_0020;
        send(7, 2);
        chk(cpu_irq_o == 1, "R9 pulse", int'(cpu_irq_o), 1);
        @(negedge clk);
        chk(cpu_irq_o == 0, "R9 not held", int'(cpu_irq_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periph();
        t_fixed();
        t_expansion();
        t_hold();
        t_level();
        t_passthrough();
        t_edge();
        t_edge_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule